// File: doc/BRIEF.md
# Frame-Difference Foreground Pixel Classifier

A streaming, one-pixel-per-clock motion detector for video at full frame rate. Each beat carries one pixel's current RGB value, the same pixel's RGB value from the previous frame, and that pixel's stored cluster state. The block returns the per-channel residual |current − previous|, a foreground flag, a flag saying whether the matched cluster counts as background, and the updated cluster state for the caller to write back.

Classification works on an intensity value Y = floor((R + 2·G + B) / 4). Each pixel owns K clusters, each holding a centre, a half-range and a weight. A pixel is foreground when Y fits no cluster. It is also foreground when it lands in the same cluster as in the previous frame and both this frame's and the previous frame's Y lie outside a narrowed band around that cluster's centre. The band width is a set percentage of the half-range. Frame storage, camera-motion compensation and object extraction are outside this block. The state travels with the pixel as sideband data.

The state word is laid out as follows. Cluster i sits at bits [24i+23:24i]: the centre in the top byte, the half-range in the middle byte and the weight in the low byte. Above the clusters are the previous-match index (IDX_W bits) and, in the top bit, that index's valid flag. RGB ports carry R in [23:16], G in [15:8] and B in [7:0].

Top module: `fg_pixel_classifier`

## Requirements
- R1: resid_o holds |cur − prev| for each channel, in the channel's own byte position.
- R2: Y = floor((R + 2G + B)/4) of the current pixel. Cluster i matches when |Y − centre_i| ≤ half_i, a distance equal to the half-range included. When several clusters match, the lowest index is chosen.
- R3: With no match, fg_o = 1. The cluster with the lowest weight is replaced, the lowest index winning a tie: its centre becomes Y, its half-range becomes DEF_HALF and its weight becomes 1. Every other cluster's weight drops by 1, stopping at 0. The previous-match index and its valid bit are written as 0.
- R4: With a match, the matched cluster's weight rises by 1 and stops at 255. Every other weight drops by 1 and stops at 0. Centres and half-ranges are unchanged. The index field takes the matched index and the valid bit is set to 1.
- R5: With a match, fg_o = 1 only under all of these conditions: the incoming valid bit is 1; the incoming index equals the match; and both |Y − centre| and |Yprev − centre| are strictly greater than floor(half × BAND_PCT / 100). Otherwise fg_o = 0.
- R6: bg_hit_o = 1 when the matched cluster belongs to the background set, judged on the incoming weights. A cluster is in the set when the sum of the weights ranked ahead of it is ≤ THRESH. A cluster ranks ahead when its weight is higher, or when the weights are equal and its index is lower. With no match, bg_hit_o = 0.
- R7: A pixel accepted at one clock edge appears on the outputs right after the second following edge, provided the output is not stalled. sof_o and eol_o travel with their pixel.
- R8: While out_valid_o = 1 and out_ready_i = 0, all outputs hold steady. No pixel is lost, duplicated or reordered.
- R9: During and right after reset, out_valid_o = 0 and in_ready_o = 1.
- R10: While out_ready_i stays high, in_ready_o stays high, so one pixel is taken every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Block can take a beat |
| sof_i | input | 1 | First pixel of frame |
| eol_i | input | 1 | Last pixel of line |
| cur_rgb_i | input | 24 | Current frame pixel |
| prev_rgb_i | input | 24 | Previous frame pixel |
| state_i | input | STATE_W | Stored cluster state |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Consumer can take a beat |
| sof_o | output | 1 | First-of-frame flag, delayed |
| eol_o | output | 1 | End-of-line flag, delayed |
| fg_o | output | 1 | Foreground flag |
| bg_hit_o | output | 1 | Matched cluster is background |
| resid_o | output | 24 | Per-channel residual |
| state_o | output | STATE_W | Updated cluster state for write-back |

## Verification
The bench builds the block with K = 4, BAND_PCT = 50, THRESH = 100 and DEF_HALF = 16. Four clusters fill a two-bit index completely, which lets the bench test priority among more than two overlapping clusters and a lowest-weight tie between middle indices. A threshold of 100 with weights such as 80/30/30/5 moves the background-set cut between two equal-weight clusters, which exposes the tie-ranking rule. A 50 % band on a half-range of 20 gives a band of 10, so the bench can place Y exactly on the band edge, exactly on the match edge, and one step beyond each.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
  parameter int unsigned PIX_W = 8;

  typedef logic [PIX_W-1:0] pix_t;

  typedef struct packed {
    pix_t r;
    pix_t g;
    pix_t b;
  } rgb_t;

  typedef struct packed {
    pix_t centre;
    pix_t half;
    pix_t weight;
  } clus_t;

  localparam int unsigned CLUS_W = $bits(clus_t);
  localparam int unsigned RGB_W  = $bits(rgb_t);

  function automatic pix_t abs_diff(input pix_t a, input pix_t b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic pix_t luma(input rgb_t p);
    logic [PIX_W+1:0] s;
    s = {2'b00, p.r} + {1'b0, p.g, 1'b0} + {2'b00, p.b};
    return s[PIX_W+1:2];
  endfunction
endpackage

// File: rtl/fgc_front.sv
module fgc_front
  import fgc_pkg::*;
(
  input  rgb_t cur_i,
  input  rgb_t prev_i,
  output rgb_t resid_o,
  output pix_t y_cur_o,
  output pix_t y_prev_o
);
  logic [2:0][PIX_W-1:0] c_ch, p_ch, r_ch;

  assign c_ch = cur_i;
  assign p_ch = prev_i;

  for (genvar ch = 0; ch < 3; ch++) begin : g_ch
    assign r_ch[ch] = abs_diff(c_ch[ch], p_ch[ch]);
  end

  assign resid_o  = r_ch;
  assign y_cur_o  = luma(cur_i);
  assign y_prev_o = luma(prev_i);
endmodule

// File: rtl/fgc_match.sv
module fgc_match
  import fgc_pkg::*;
#(
  parameter int unsigned K      = 3,
  parameter int unsigned IDX_W  = (K > 1) ? $clog2(K) : 1,
  parameter int unsigned THRESH = 128
) (
  input  pix_t             y_i,
  input  clus_t [K-1:0]    clus_i,
  output logic             hit_any_o,
  output logic [IDX_W-1:0] midx_o,
  output logic [IDX_W-1:0] lowidx_o,
  output logic             bg_o
);
  localparam int unsigned SUM_W = PIX_W + $clog2(K + 1);

  logic [K-1:0]       hit;
  logic [K-1:0]       in_set;
  logic [SUM_W-1:0]   pre_sum [K];
  pix_t               wmin;

  for (genvar i = 0; i < K; i++) begin : g_clus
    assign hit[i] = abs_diff(y_i, clus_i[i].centre) <= clus_i[i].half;

    // weight of every cluster ranked ahead of this one
    always_comb begin
      pre_sum[i] = '0;
      for (int j = 0; j < K; j++) begin
        if ((clus_i[j].weight > clus_i[i].weight) ||
            ((clus_i[j].weight == clus_i[i].weight) && (j < i)))
          pre_sum[i] = pre_sum[i] + SUM_W'(clus_i[j].weight);
      end
      in_set[i] = (32'(pre_sum[i]) <= THRESH);
    end
  end

  always_comb begin
    hit_any_o = 1'b0;
    midx_o    = '0;
    for (int i = K - 1; i >= 0; i--) begin
      if (hit[i]) begin
        hit_any_o = 1'b1;
        midx_o    = IDX_W'(i);
      end
    end
  end

  always_comb begin
    wmin     = clus_i[0].weight;
    lowidx_o = '0;
    for (int i = 1; i < K; i++) begin
      if (clus_i[i].weight < wmin) begin
        wmin     = clus_i[i].weight;
        lowidx_o = IDX_W'(i);
      end
    end
  end

  assign bg_o = hit_any_o & in_set[midx_o];
endmodule

// File: rtl/fgc_update.sv
module fgc_update
  import fgc_pkg::*;
#(
  parameter int unsigned K        = 3,
  parameter int unsigned IDX_W    = (K > 1) ? $clog2(K) : 1,
  parameter int unsigned BAND_PCT = 50,
  parameter int unsigned DEF_HALF = 16
) (
  input  pix_t             y_cur_i,
  input  pix_t             y_prev_i,
  input  clus_t [K-1:0]    clus_i,
  input  logic [IDX_W-1:0] prev_idx_i,
  input  logic             prev_vld_i,
  input  logic             hit_any_i,
  input  logic [IDX_W-1:0] midx_i,
  input  logic [IDX_W-1:0] lowidx_i,
  output logic             fg_o,
  output clus_t [K-1:0]    clus_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  localparam int unsigned BW = PIX_W + 8;

  clus_t          mc;
  logic [BW-1:0]  band;
  logic           out_cur, out_prev, repeat_fg;

  assign mc       = clus_i[midx_i];
  assign band     = ({8'b0, mc.half} * BW'(BAND_PCT)) / BW'(100);
  assign out_cur  = {8'b0, abs_diff(y_cur_i,  mc.centre)} > band;
  assign out_prev = {8'b0, abs_diff(y_prev_i, mc.centre)} > band;

  assign repeat_fg = hit_any_i & prev_vld_i & (prev_idx_i == midx_i) & out_cur & out_prev;
  assign fg_o      = ~hit_any_i | repeat_fg;

  for (genvar i = 0; i < K; i++) begin : g_upd
    clus_t nxt;
    always_comb begin
      nxt = clus_i[i];
      if (hit_any_i && (midx_i == IDX_W'(i))) begin
        if (clus_i[i].weight != '1) nxt.weight = clus_i[i].weight + 1'b1;
      end else if (!hit_any_i && (lowidx_i == IDX_W'(i))) begin
        nxt.centre = y_cur_i;
        nxt.half   = PIX_W'(DEF_HALF);
        nxt.weight = PIX_W'(1);
      end else if (clus_i[i].weight != '0) begin
        nxt.weight = clus_i[i].weight - 1'b1;
      end
    end
    assign clus_o[i] = nxt;
  end

  assign idx_o = hit_any_i ? midx_i : '0;
  assign vld_o = hit_any_i;
endmodule

// File: rtl/fg_pixel_classifier.sv
module fg_pixel_classifier
  import fgc_pkg::*;
#(
  parameter int unsigned K        = 3,
  parameter int unsigned BAND_PCT = 50,
  parameter int unsigned THRESH   = 128,
  parameter int unsigned DEF_HALF = 16,
  parameter int unsigned IDX_W    = (K > 1) ? $clog2(K) : 1,
  parameter int unsigned STATE_W  = K * 24 + IDX_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic               sof_i,
  input  logic               eol_i,
  input  logic [23:0]        cur_rgb_i,
  input  logic [23:0]        prev_rgb_i,
  input  logic [STATE_W-1:0] state_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic               sof_o,
  output logic               eol_o,
  output logic               fg_o,
  output logic               bg_hit_o,
  output logic [23:0]        resid_o,
  output logic [STATE_W-1:0] state_o
);
  localparam int unsigned CL_W = K * CLUS_W;

  typedef struct packed {
    logic               sof;
    logic               eol;
    rgb_t               res;
    pix_t               yc;
    pix_t               yp;
    logic [STATE_W-1:0] st;
  } s1_t;

  typedef struct packed {
    s1_t                b;
    logic               hit;
    logic [IDX_W-1:0]   midx;
    logic [IDX_W-1:0]   lowidx;
    logic               bg;
  } s2_t;

  typedef struct packed {
    logic               sof;
    logic               eol;
    logic               fg;
    logic               bg;
    rgb_t               res;
    logic [STATE_W-1:0] st;
  } s3_t;

  logic en, acc;
  logic v1, v2, v3;
  s1_t  s1, s1_d;
  s2_t  s2, s2_d;
  s3_t  s3, s3_d;

  assign en         = ~v3 | out_ready_i;
  assign acc        = in_valid_i & en;
  assign in_ready_o = en;

  // stage 1: residual and intensity
  rgb_t f_res;
  pix_t f_yc, f_yp;

  fgc_front u_front (
    .cur_i    (rgb_t'(cur_rgb_i)),
    .prev_i   (rgb_t'(prev_rgb_i)),
    .resid_o  (f_res),
    .y_cur_o  (f_yc),
    .y_prev_o (f_yp)
  );

  assign s1_d = '{sof: sof_i, eol: eol_i, res: f_res, yc: f_yc, yp: f_yp, st: state_i};

  // stage 2: cluster match
  clus_t [K-1:0]    s1_clus;
  logic             m_hit, m_bg;
  logic [IDX_W-1:0] m_idx, m_low;

  assign s1_clus = s1.st[CL_W-1:0];

  fgc_match #(.K(K), .IDX_W(IDX_W), .THRESH(THRESH)) u_match (
    .y_i       (s1.yc),
    .clus_i    (s1_clus),
    .hit_any_o (m_hit),
    .midx_o    (m_idx),
    .lowidx_o  (m_low),
    .bg_o      (m_bg)
  );

  assign s2_d = '{b: s1, hit: m_hit, midx: m_idx, lowidx: m_low, bg: m_bg};

  // stage 3: decision and state update
  clus_t [K-1:0]    s2_clus, u_clus;
  logic             u_fg, u_vld;
  logic [IDX_W-1:0] u_idx;

  assign s2_clus = s2.b.st[CL_W-1:0];

  fgc_update #(.K(K), .IDX_W(IDX_W), .BAND_PCT(BAND_PCT), .DEF_HALF(DEF_HALF)) u_update (
    .y_cur_i    (s2.b.yc),
    .y_prev_i   (s2.b.yp),
    .clus_i     (s2_clus),
    .prev_idx_i (s2.b.st[STATE_W-2 -: IDX_W]),
    .prev_vld_i (s2.b.st[STATE_W-1]),
    .hit_any_i  (s2.hit),
    .midx_i     (s2.midx),
    .lowidx_i   (s2.lowidx),
    .fg_o       (u_fg),
    .clus_o     (u_clus),
    .idx_o      (u_idx),
    .vld_o      (u_vld)
  );

  assign s3_d = '{sof: s2.b.sof, eol: s2.b.eol, fg: u_fg, bg: s2.bg,
                  res: s2.b.res, st: {u_vld, u_idx, u_clus}};

  // stall-all pipeline: every stage moves only when the output can drain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else if (en) begin
      v1 <= in_valid_i;
      v2 <= v1;
      v3 <= v2;
      s1 <= s1_d;
      s2 <= s2_d;
      s3 <= s3_d;
    end
  end

  assign out_valid_o = v3;
  assign sof_o       = s3.sof;
  assign eol_o       = s3.eol;
  assign fg_o        = s3.fg;
  assign bg_hit_o    = s3.bg;
  assign resid_o     = s3.res;
  assign state_o     = s3.st;

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 3) && $past(acc, 3) && $past(en, 2) && $past(en, 1)) |-> out_valid_o); // R7

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(fg_o) && $stable(resid_o)
                                       && $stable(state_o) && $stable(bg_hit_o))); // R8

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> !out_valid_o); // R9

  AST_MISS_IS_FG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !state_o[STATE_W-1]) |-> fg_o); // R3

  AST_BG_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && bg_hit_o) |-> state_o[STATE_W-1]); // R6

  AST_PRIO_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v2 && s2.hit && (s2.midx != '0)) |->
      (abs_diff(s2.b.yc, s2_clus[0].centre) > s2_clus[0].half)); // R2

  AST_HIT_WEIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v3 && s3.st[STATE_W-1]) |->
      (s3.st[32'(s3.st[STATE_W-2 -: IDX_W]) * CLUS_W +: PIX_W] != '0)); // R4
endmodule

// File: tb/fg_pixel_classifier_bench.sv
module fg_pixel_classifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int K    = 4;
  localparam int BPCT = 50;
  localparam int TH   = 100;
  localparam int DH   = 16;
  localparam int IW   = 2;
  localparam int SW   = K * 24 + IW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, sof = 1'b0, eol = 1'b0;
  logic [23:0] cur = '0, prev = '0;
  logic [SW-1:0] st_in = '0;
  logic out_valid, out_ready = 1'b1, sof_o, eol_o, fg, bg;
  logic [23:0] resid;
  logic [SW-1:0] st_out;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fg_pixel_classifier #(.K(K), .BAND_PCT(BPCT), .THRESH(TH), .DEF_HALF(DH)) u_fg_pixel_classifier (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .sof_i(sof), .eol_i(eol), .cur_rgb_i(cur), .prev_rgb_i(prev), .state_i(st_in),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .sof_o(sof_o), .eol_o(eol_o),
    .fg_o(fg), .bg_hit_o(bg), .resid_o(resid), .state_o(st_out)
  );

  typedef struct {
    logic fg, bg, sof, eol;
    logic [23:0] res;
    logic [SW-1:0] st;
    string tag;
    int pc;
    bit lat;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, cyc = 0;
  bit stall_mode = 1'b0;
  int tc[K], th[K], tw[K];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int absi(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int y_of(input logic [23:0] p);
    return (int'(p[23:16]) + 2 * int'(p[15:8]) + int'(p[7:0])) / 4;
  endfunction

  function automatic exp_t model(input logic [23:0] c_in, input logic [23:0] p_in, input logic [SW-1:0] s);
    exp_t r;
    int c[K], h[K], w[K];
    int yc, yp, m, lo, pre, band, pidx;
    bit pv;
    for (int i = 0; i < K; i++) begin
      c[i] = int'(s[i*24+16 +: 8]);
      h[i] = int'(s[i*24+8 +: 8]);
      w[i] = int'(s[i*24 +: 8]);
    end
    pv = s[SW-1];
    pidx = int'(s[SW-2 -: IW]);
    for (int ch = 0; ch < 3; ch++)
      r.res[ch*8 +: 8] = 8'(absi(int'(c_in[ch*8 +: 8]) - int'(p_in[ch*8 +: 8])));
    yc = y_of(c_in);
    yp = y_of(p_in);
    m = -1;
    for (int i = 0; i < K; i++) if (m < 0 && absi(yc - c[i]) <= h[i]) m = i;
    r.st = '0;
    if (m >= 0) begin
      pre = 0;
      for (int j = 0; j < K; j++)
        if (w[j] > w[m] || (w[j] == w[m] && j < m)) pre += w[j];
      r.bg = (pre <= TH);
      band = h[m] * BPCT / 100;
      r.fg = pv && (pidx == m) && (absi(yc - c[m]) > band) && (absi(yp - c[m]) > band);
      for (int i = 0; i < K; i++)
        if (i == m) w[i] = (w[i] < 255) ? w[i] + 1 : 255;
        else w[i] = (w[i] > 0) ? w[i] - 1 : 0;
      r.st[SW-1] = 1'b1;
      r.st[SW-2 -: IW] = IW'(m);
    end else begin
      r.bg = 1'b0;
      r.fg = 1'b1;
      lo = 0;
      for (int i = 1; i < K; i++) if (w[i] < w[lo]) lo = i;
      for (int i = 0; i < K; i++)
        if (i == lo) begin c[i] = yc; h[i] = DH; w[i] = 1; end
        else w[i] = (w[i] > 0) ? w[i] - 1 : 0;
    end
    for (int i = 0; i < K; i++) r.st[i*24 +: 24] = {8'(c[i]), 8'(h[i]), 8'(w[i])};
    return r;
  endfunction

  task automatic set_cl(input int i, input int c, input int h, input int w);
    tc[i] = c; th[i] = h; tw[i] = w;
  endtask

  function automatic logic [SW-1:0] mk(input int pidx, input bit pv);
    logic [SW-1:0] s;
    s = '0;
    for (int i = 0; i < K; i++) s[i*24 +: 24] = {8'(tc[i]), 8'(th[i]), 8'(tw[i])};
    s[SW-2 -: IW] = IW'(pidx);
    s[SW-1] = pv;
    return s;
  endfunction

  function automatic logic [23:0] gray(input int v);
    return {8'(v), 8'(v), 8'(v)};
  endfunction

  // call right after a rising edge; returns right after the accepting edge
  task automatic send(input string tag, input logic [23:0] c_in, input logic [23:0] p_in,
                      input logic [SW-1:0] s, input logic sf, input logic el, input bit rate_chk);
    exp_t e;
    e = model(c_in, p_in, s);
    e.tag = tag; e.sof = sf; e.eol = el;
    in_valid = 1'b1; cur = c_in; prev = p_in; st_in = s; sof = sf; eol = el;
    forever begin
      @(negedge clk);
      if (rate_chk) chk("R10", "in_ready", 128'(in_ready), 128'(1));
      if (in_ready) break;
    end
    e.pc = cyc;
    e.lat = !stall_mode;
    q.push_back(e);
    @(posedge clk); #1;
    in_valid = 1'b0; sof = 1'b0; eol = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && q.size() != 0; i++) @(posedge clk);
    @(posedge clk); #1;
  endtask

  // output monitor and stall-hold checker
  bit hold_pend = 1'b0;
  logic [SW+27:0] snap;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        chk("R8", "valid held", 128'(out_valid), 128'(1));
        chk("R8", "outputs held", 128'({st_out, resid, fg, bg, sof_o, eol_o}), 128'(snap));
      end
      hold_pend = out_valid && !out_ready;
      snap = {st_out, resid, fg, bg, sof_o, eol_o};
      if (out_valid && out_ready) begin
        if (q.size() == 0) chk("R8", "spurious output", 128'(1), 128'(0));
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.tag, "fg", 128'(fg), 128'(e.fg));
          chk(e.tag, "state", 128'(st_out), 128'(e.st));
          chk("R1", "resid", 128'(resid), 128'(e.res));
          chk("R6", "bg_hit", 128'(bg), 128'(e.bg));
          chk("R7", "sof/eol", 128'({sof_o, eol_o}), 128'({e.sof, e.eol}));
          if (e.lat) chk("R7", "latency", 128'(cyc - e.pc), 128'(3));
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (stall_mode) out_ready = ($urandom_range(0, 2) != 0);
    else out_ready = 1'b1;
  end

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "valid in reset", 128'(out_valid), 128'(0));
    chk("R9", "ready in reset", 128'(in_ready), 128'(1));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "valid after reset", 128'(out_valid), 128'(0));
    @(posedge clk); #1;
  endtask

  task automatic t_residual();
    for (int i = 0; i < K; i++) set_cl(i, 40 * i, 4, 10);
    send("R1", {8'd200, 8'd10, 8'd128}, {8'd50, 8'd40, 8'd128}, mk(0, 0), 1'b0, 1'b0, 1'b0);
    send("R1", {8'd0, 8'd255, 8'd7}, {8'd255, 8'd0, 8'd9}, mk(1, 1), 1'b0, 1'b0, 1'b0);
    drain();
  endtask

  task automatic t_priority();
    set_cl(0, 10, 5, 50); set_cl(1, 95, 10, 40); set_cl(2, 100, 0, 30); set_cl(3, 100, 50, 20);
    send("R2", {8'd0, 8'd200, 8'd0}, gray(100), mk(0, 0), 1'b0, 1'b0, 1'b0);
    set_cl(1, 0, 0, 40);
    send("R2", gray(100), gray(100), mk(0, 0), 1'b0, 1'b0, 1'b0);
    drain();
  endtask

  task automatic t_boundary();
    set_cl(0, 50, 8, 10); set_cl(1, 200, 2, 0); set_cl(2, 220, 2, 0); set_cl(3, 240, 2, 7);
    send("R2", gray(58), gray(58), mk(3, 1), 1'b0, 1'b0, 1'b0);
    send("R3", gray(59), gray(59), mk(3, 1), 1'b0, 1'b0, 1'b0);
    set_cl(1, 200, 2, 3); set_cl(2, 220, 2, 3);
    send("R3", gray(42), gray(42), mk(2, 1), 1'b0, 1'b0, 1'b0);
    drain();
  endtask

  task automatic t_saturate();
    set_cl(0, 30, 3, 255); set_cl(1, 90, 3, 0); set_cl(2, 150, 3, 1); set_cl(3, 210, 3, 254);
    send("R4", gray(31), gray(0), mk(0, 0), 1'b0, 1'b0, 1'b0);
    send("R4", gray(210), gray(0), mk(0, 1), 1'b0, 1'b0, 1'b0);
    drain();
  endtask

  task automatic t_repeat();
    set_cl(0, 100, 20, 50); set_cl(1, 10, 1, 20); set_cl(2, 200, 1, 20); set_cl(3, 240, 1, 20);
    send("R5", gray(115), gray(85), mk(0, 1), 1'b0, 1'b0, 1'b0);
    send("R5", gray(115), gray(105), mk(0, 1), 1'b0, 1'b0, 1'b0);
    send("R5", gray(110), gray(85), mk(0, 1), 1'b0, 1'b0, 1'b0);
    send("R5", gray(111), gray(89), mk(0, 1), 1'b0, 1'b0, 1'b0);
    send("R5", gray(115), gray(85), mk(0, 0), 1'b0, 1'b0, 1'b0);
    send("R5", gray(115), gray(85), mk(1, 1), 1'b0, 1'b0, 1'b0);
    drain();
  endtask

  task automatic t_bgset();
    set_cl(0, 20, 5, 80); set_cl(1, 60, 5, 30); set_cl(2, 100, 5, 30); set_cl(3, 140, 5, 5);
    send("R6", gray(100), gray(0), mk(0, 0), 1'b0, 1'b0, 1'b0);
    send("R6", gray(60), gray(0), mk(0, 0), 1'b0, 1'b0, 1'b0);
    send("R6", gray(140), gray(0), mk(0, 0), 1'b0, 1'b0, 1'b0);
    send("R6", gray(20), gray(0), mk(0, 0), 1'b0, 1'b0, 1'b0);
    drain();
  endtask

  task automatic rand_state(output logic [SW-1:0] s);
    for (int i = 0; i < K; i++)
      set_cl(i, $urandom_range(0, 255), $urandom_range(0, 40), $urandom_range(0, 255));
    s = mk($urandom_range(0, 3), 1'($urandom_range(0, 1)));
  endtask

  task automatic t_stream();
    for (int n = 0; n < 12; n++) begin
      logic [SW-1:0] s;
      rand_state(s);
      send("R7", 24'($urandom), 24'($urandom), s, n == 0, n == 11, 1'b1);
    end
    drain();
  endtask

  task automatic t_backpressure();
    int sent;
    sent = 0;
    stall_mode = 1'b1;
    for (int n = 0; n < 40; n++) begin
      logic [SW-1:0] s;
      rand_state(s);
      send("R8", 24'($urandom), 24'($urandom), s, n % 8 == 0, n % 8 == 7, 1'b0);
      sent++;
    end
    drain();
    stall_mode = 1'b0;
    repeat (2) @(posedge clk);
    chk("R8", "all delivered", 128'(q.size()), 128'(0));
    chk("R8", "pixels sent", 128'(sent), 128'(40));
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_residual();
    t_priority();
    t_boundary();
    t_saturate();
    t_repeat();
    t_bgset();
    t_stream();
    t_backpressure();
    summary();
    $finish;
  end
endmodule